// File: doc/BRIEF.md
# Programmable Multi-Range Input Debouncer

This block cleans up a 32-bit parallel input bus before it reaches the edge-detection logic. The bus is split into four 8-bit ports. Each bit's output takes a new level only after the raw level has held steady for a chosen window. The block runs from an 8 MHz system clock. A free-running prescaler, one per window range, issues a sample tick. A bit's filter accepts a new level after four consecutive tick samples that all disagree with its current output. This gives each window a minimum and a maximum of three to four tick periods.

A small write port sets three things: which ports are filtered, a 2-bit window code for each port, and a timebase switch. The timebase runs only when its register holds exactly 01h. A port whose filter is disabled, or any port while the timebase is off, passes its raw input through a two-flop synchronizer and no more. While a bit is bypassed, its filter register keeps tracking the synchronized level. Because of this, switching filtering on, or leaving reset, never creates a false edge.

Top module: `din_debounce`

## Requirements
- R1: After reset all port enables are 0, every window code is 0 and the timebase is off. Setting only the enable register (address 0) therefore still leaves every port in pass-through.
- R2: A bit of a port that is not actively filtered shows the raw input exactly two clock cycles later.
- R3: The timebase runs only while the last value written to address 3 is 01h. Any other value stops the prescalers and puts every port into pass-through.
- R4: An actively filtered bit changes its output only on a sample tick of its port. The change happens on the fourth consecutive tick at which the synchronized input disagrees with the output, so the delay after the synchronizer is 3×P+1 to 4×P cycles for tick period P.
- R5: Address 1 holds each port's window code, with port p in bits [2p+1:2p]. The tick periods are 8, 128, 2000 and 16000 cycles for codes 0 to 3: windows of 3–4 µs, 48–64 µs, 0.75–1 ms and 6–8 ms.
- R6: A tick sample that agrees with the current output drops that bit's filter back to its idle state, so a pulse spanning fewer than four ticks is removed.
- R7: Writes to address 2 change nothing.
- R8: Bit p of address 0 enables filtering of port p (bits 8p+7..8p). Bits 7:4 are ignored.
- R9: While a bit is not filtered, its filter register loads the synchronized input every cycle, so enabling filtering does not change the output.
- R10: During reset every filter register loads the synchronized input, so the output after reset equals the raw level with no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 enables, 1 window codes, 2 unused, 3 timebase |
| wr_data | input | 8 | Register write data |
| raw_in | input | 32 | Raw input bus, asynchronous |
| clean_out | output | 32 | Debounced bus |

## Verification
Each bit's filter runs a four-state machine. HOLD is the idle state, where the input agrees with the output. SEEN1, SEEN2 and SEEN3 count disagreeing samples. On a tick, HOLD advances to SEEN1 and each SEENn state advances to the next. SEEN3 does ACCEPT: it flips the output and returns to HOLD. RESTART returns any state to HOLD on an agreeing tick, and BYPASS forces HOLD when the port is not active. A stuck or skipped state shows at the ports as an output edge one tick early or late, or as a glitch that gets through, at most four tick periods after the input moves. A wrong prescaler phase or a wrong window selection moves every accepted edge of that port off its tick. A pass-through or register fault differs from the expected bus within two cycles. The bench compares the whole bus on every clock against a behavioural model.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
    typedef enum logic [1:0] {
        HOLD  = 2'd0,
        SEEN1 = 2'd1,
        SEEN2 = 2'd2,
        SEEN3 = 2'd3
    } flt_state_e;

    localparam logic [1:0] A_FILT_EN = 2'd0;
    localparam logic [1:0] A_WIN_LO  = 2'd1;
    localparam logic [1:0] A_WIN_HI  = 2'd2;
    localparam logic [1:0] A_TB_SEL  = 2'd3;
    localparam logic [7:0] TB_ON_CODE = 8'h01;
endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs
    import dbnc_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [7:0]             wr_data,
    output logic [N_PORTS-1:0]     port_en,
    output logic [2*N_PORTS-1:0]   win_code,
    output logic                   tb_on
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en  <= '0;
            win_code <= '0;
            tb_on    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_FILT_EN: port_en  <= wr_data[N_PORTS-1:0];
                A_WIN_LO:  win_code <= wr_data[2*N_PORTS-1:0];
                A_WIN_HI:  ;
                A_TB_SEL:  tb_on    <= (wr_data == TB_ON_CODE);
            endcase
        end
    end
endmodule

// File: rtl/dbnc_prescale.sv
module dbnc_prescale #(
    parameter int T0 = 8,
    parameter int T1 = 128,
    parameter int T2 = 2000,
    parameter int T3 = 16000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [3:0] tick
);
    localparam int PER [4] = '{T0, T1, T2, T3};

    for (genvar k = 0; k < 4; k++) begin : g_div
        localparam int CW = $clog2(PER[k]);
        localparam logic [CW-1:0] LAST = CW'(PER[k] - 1);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end

        assign tick[k] = run && (cnt == LAST);
    end
endmodule

// File: rtl/dbnc_port.sv
module dbnc_port
    import dbnc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout
);
    for (genvar g = 0; g < PORT_W; g++) begin : g_bit
        flt_state_e st_q, st_d;
        logic       hold_q, hold_d;

        // next-state and output-register logic
        always_comb begin
            st_d   = st_q;
            hold_d = hold_q;
            if (!active) begin
                st_d   = HOLD;          // BYPASS
                hold_d = din[g];
            end else if (tick) begin
                if (din[g] == hold_q) begin
                    st_d = HOLD;        // RESTART
                end else begin
                    unique case (st_q)
                        HOLD:  st_d = SEEN1;
                        SEEN1: st_d = SEEN2;
                        SEEN2: st_d = SEEN3;
                        SEEN3: begin    // ACCEPT
                            st_d   = HOLD;
                            hold_d = din[g];
                        end
                    endcase
                end
            end
        end

        // state register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= HOLD;
                hold_q <= din[g];
            end else begin
                st_q   <= st_d;
                hold_q <= hold_d;
            end
        end

        assign dout[g] = active ? hold_q : din[g];
    end
endmodule

// File: rtl/din_debounce.sv
module din_debounce
    import dbnc_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int PORT_W  = 8,
    parameter int TICK0   = 8,
    parameter int TICK1   = 128,
    parameter int TICK2   = 2000,
    parameter int TICK3   = 16000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic [N_PORTS*PORT_W-1:0]   raw_in,
    output logic [N_PORTS*PORT_W-1:0]   clean_out
);
    localparam int BUS_W = N_PORTS * PORT_W;

    logic [BUS_W-1:0]     sync1, sync2;
    logic [N_PORTS-1:0]   port_en, port_act, port_tick;
    logic [2*N_PORTS-1:0] win_code;
    logic                 tb_on;
    logic [3:0]           tick_all;

    always_ff @(posedge clk) begin
        sync1 <= raw_in;
        sync2 <= sync1;
    end

    dbnc_regs #(.N_PORTS(N_PORTS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_en(port_en), .win_code(win_code), .tb_on(tb_on)
    );

    dbnc_prescale #(.T0(TICK0), .T1(TICK1), .T2(TICK2), .T3(TICK3)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(tb_on), .tick(tick_all)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [1:0] code;
        assign code         = win_code[2*p +: 2];
        assign port_tick[p] = tick_all[code];
        assign port_act[p]  = port_en[p] & tb_on;

        dbnc_port #(.PORT_W(PORT_W)) u_port (
            .clk(clk), .rst_n(rst_n), .active(port_act[p]), .tick(port_tick[p]),
            .din(sync2[p*PORT_W +: PORT_W]), .dout(clean_out[p*PORT_W +: PORT_W])
        );
    end
endmodule

// File: rtl/din_debounce_chk.sv
module din_debounce_chk #(
    parameter int N_PORTS = 4,
    parameter int PORT_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [1:0]                wr_addr,
    input logic [7:0]                wr_data,
    input logic [N_PORTS*PORT_W-1:0] raw_in,
    input logic [N_PORTS*PORT_W-1:0] clean_out,
    input logic [N_PORTS-1:0]        port_en,
    input logic [N_PORTS-1:0]        port_act,
    input logic [N_PORTS-1:0]        port_tick,
    input logic [2*N_PORTS-1:0]      win_code,
    input logic                      tb_on
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end

    assert_tb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_on && cyc >= 2'd2) |-> clean_out == $past(raw_in, 2));

    assert_cfg_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=>
        (win_code == $past(win_code) && port_en == $past(port_en) && tb_on == $past(tb_on)));

    assert_enable_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> port_en == $past(wr_data[N_PORTS-1:0]));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
        assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!port_act[p] && cyc >= 2'd2) |->
            clean_out[p*PORT_W +: PORT_W] == $past(raw_in[p*PORT_W +: PORT_W], 2));

        assert_edge_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd1 && port_act[p] && $past(port_act[p]) &&
             clean_out[p*PORT_W +: PORT_W] != $past(clean_out[p*PORT_W +: PORT_W]))
            |-> $past(port_tick[p]));
    end
endmodule

bind din_debounce din_debounce_chk #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .raw_in(raw_in), .clean_out(clean_out), .port_en(port_en), .port_act(port_act),
    .port_tick(port_tick), .win_code(win_code), .tb_on(tb_on)
);

// File: tb/sim_din_debounce.sv
module sim_din_debounce;
    localparam int PER [4] = '{8, 128, 2000, 16000};

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] raw_in = '0;
    logic [31:0] clean_out;
    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    din_debounce u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .raw_in(raw_in), .clean_out(clean_out));

    // behavioural reference model
    logic [31:0] m_s1 = '0, m_s2 = '0, m_hold = '0;
    int          m_sc [32];
    int          m_cnt [4];
    logic [3:0]  m_en = '0;
    logic [7:0]  m_win = '0;
    bit          m_tb = 1'b0;

    initial begin
        for (int i = 0; i < 32; i++) m_sc[i] = 0;
        for (int k = 0; k < 4; k++) m_cnt[k] = 0;
    end

    function automatic bit act_of(int p);
        return m_en[p] && m_tb;
    endfunction

    always @(posedge clk) begin : model
        bit [3:0] mt;
        int code;
        for (int k = 0; k < 4; k++) mt[k] = m_tb && (m_cnt[k] == PER[k] - 1);
        for (int p = 0; p < 4; p++) begin
            code = int'(m_win[2*p +: 2]);
            for (int b = 0; b < 8; b++) begin
                int i;
                i = p*8 + b;
                if (!rst_n || !act_of(p)) begin
                    m_hold[i] = m_s2[i];
                    m_sc[i]   = 0;
                end else if (mt[code]) begin
                    if (m_s2[i] == m_hold[i]) m_sc[i] = 0;
                    else if (m_sc[i] == 3) begin
                        m_hold[i] = m_s2[i];
                        m_sc[i]   = 0;
                    end else m_sc[i] = m_sc[i] + 1;
                end
            end
        end
        for (int k = 0; k < 4; k++)
            if (!rst_n || !m_tb) m_cnt[k] = 0;
            else m_cnt[k] = (m_cnt[k] == PER[k] - 1) ? 0 : m_cnt[k] + 1;
        if (!rst_n) begin
            m_en = '0; m_win = '0; m_tb = 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: m_en  = wr_data[3:0];
                2'd1: m_win = wr_data;
                2'd3: m_tb  = (wr_data == 8'h01);
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = raw_in;
    end

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #4;
        if (rst_n && !done) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] exp;
                string tag;
                exp = act_of(p) ? m_hold[p*8 +: 8] : m_s2[p*8 +: 8];
                tag = act_of(p) ? "R4" : (m_en[p] ? "R3" : "R2");
                checks++;
                if (clean_out[p*8 +: 8] !== exp) begin
                    failures++;
                    $display("FAIL %s model port %0d got %h exp %h", tag, p,
                             clean_out[p*8 +: 8], exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog (all requirements) got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] exp);
        checks++;
        if (clean_out !== exp) begin
            failures++;
            $display("FAIL %s got %h exp %h", tag, clean_out, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        raw_in = 32'hA5C3_0F81;
        waitn(5);
        rst_n = 1'b1;
        waitn(1);
        chk("R10", 32'hA5C3_0F81);          // reset loads synced level

        raw_in = 32'h5A3C_F07E;             // R2: two-cycle pass-through
        waitn(1); chk("R2", 32'hA5C3_0F81);
        waitn(1); chk("R2", 32'h5A3C_F07E);

        wr(2'd0, 8'h0F);                    // R1: timebase off by default
        raw_in = 32'h0;
        waitn(2); chk("R1", 32'h0);

        wr(2'd3, 8'h03);                    // R3: only 01h starts timebase
        raw_in = 32'hFFFF_FFFF;
        waitn(2); chk("R3", 32'hFFFF_FFFF);
        raw_in = 32'h0;
        waitn(2); chk("R3", 32'h0);
        wr(2'd3, 8'h01);

        raw_in = 32'h1;                     // R4: code 0 window
        waitn(20); chk("R4", 32'h0);
        waitn(20); chk("R4", 32'h1);

        raw_in = 32'h0; waitn(10); raw_in = 32'h1;   // R6: short glitches removed
        waitn(40); chk("R6", 32'h1);
        raw_in = 32'h0; waitn(20); raw_in = 32'h1;
        waitn(40); chk("R6", 32'h1);

        wr(2'd1, 8'hE4);                    // R5: codes 0,1,2,3 on ports 0..3
        raw_in = 32'h0101_0100;
        waitn(40);    chk("R5", 32'h0000_0000);
        waitn(560);   chk("R5", 32'h0000_0100);
        waitn(7500);  chk("R5", 32'h0001_0100);
        waitn(31900); chk("R5", 32'h0001_0100);
        waitn(24100); chk("R5", 32'h0101_0100);

        wr(2'd2, 8'hFF);                    // R7: address 2 ignored
        raw_in = 32'h0101_0101;
        waitn(40); chk("R7", 32'h0101_0101);

        wr(2'd0, 8'hF0);                    // R8: upper bits ignored
        raw_in = 32'h0202_0202;
        waitn(2); chk("R8", 32'h0202_0202);
        wr(2'd0, 8'h02);
        raw_in = 32'h0303_0303;
        waitn(2);   chk("R8", 32'h0303_0203);
        waitn(600); chk("R8", 32'h0303_0303);

        wr(2'd0, 8'h0F);                    // R9: enabling makes no edge
        chk("R9", 32'h0303_0303);
        waitn(1); chk("R9", 32'h0303_0303);

        waitn(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule